// File: doc/BRIEF.md
# Fractional Divide-Ratio Staging Registers

This block sits between a serial register port and two fractional-N feedback dividers, a main one and an auxiliary one. It keeps, for each divider, a 9-bit integer index (the divide ratio less 32) and a signed two's-complement fractional dividend. Each register write arrives as a strobe, a 4-bit address and a 12-bit data word. The block holds the written fields in shadow registers. It copies them into the active registers seen by the divider only when a designated final register is written. As a result, a divider never runs with an index from one setting and a dividend from another.

The main dividend is 18 bits wide. In the wide mode it is built from a 10-bit upper part and an 8-bit lower part. In the narrow mode the upper register holds all ten bits and the result is sign-extended. The auxiliary dividend is always 10 bits. When a divider is set to integer mode, writing its index changes the active index at once. Each commit raises a one-cycle update pulse for the affected divider.

Top module: `frac_ratio_stage`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every active index and dividend reads zero and both update pulses are low.
- R2: Only a write (`wr_en`=1) to address 0, 1, 2, 3 or 4 changes any state. Writes to addresses 5 to 15, and cycles with `wr_en`=0, leave all outputs unchanged and raise no update pulse.
- R3: With `main_int_mode`=0, writing address 0 (main index, data[8:0]) or address 2 (main lower dividend, data[7:0]) stores the value in a shadow register only. The main outputs do not change.
- R4: With `main_res10`=0, writing address 1 makes the active main index equal to the shadow index. It makes the active main dividend equal to {data[9:0], shadow lower byte}. Both take effect in the cycle after the write edge.
- R5: With `main_res10`=1, writing address 1 makes the active main dividend equal to data[9:0] sign-extended to 18 bits. Any lower byte written at address 2 has no effect on it. Data bits [11:10] are always ignored.
- R6: With `aux_int_mode`=0, writing address 3 (aux index, data[8:0]) only stores a shadow value. Writing address 4 commits that index together with the 10-bit dividend data[9:0].
- R7: When a divider's integer-mode bit is 1, writing its index register updates the active index in the next cycle. The active dividend of that divider is unchanged.
- R8: Every commit, including an immediate index write in integer mode, raises that divider's update pulse for exactly one cycle, the same cycle in which the new values appear. The other divider's pulse stays low.
- R9: The mode bits are sampled in the cycle of the committing write. A change of `main_res10` in that same cycle selects the layout of the value being committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register data |
| main_int_mode | input | 1 | Main divider integer mode |
| main_res10 | input | 1 | Main dividend layout: 0 = 18-bit, 1 = 10-bit |
| aux_int_mode | input | 1 | Auxiliary divider integer mode |
| main_idx_o | output | 9 | Active main index |
| main_div_o | output | 18 | Active main dividend, two's complement |
| main_upd_o | output | 1 | Main commit pulse |
| aux_idx_o | output | 9 | Active auxiliary index |
| aux_div_o | output | 10 | Active auxiliary dividend, two's complement |
| aux_upd_o | output | 1 | Auxiliary commit pulse |

## Verification
Two functions can meet in one cycle. The first is the commit through the upper dividend register. The second is the layout selection made by `main_res10`. The bench provokes the collision by writing the lower byte while the narrow layout is selected, then flipping `main_res10` to the wide layout on the very edge that writes the upper register. The result is judged by whether the committed dividend is the concatenation with the stored byte rather than a sign-extended value. A second collision occurs in integer mode, where the shadow capture and the immediate commit of one index write land on the same edge. It is judged by a later upper-register commit that must carry the same index.

// File: rtl/frac_stage_pkg.sv
package frac_stage_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 12;
    localparam int IDX_W   = 9;
    localparam int HI_W    = 10;
    localparam int LO_W    = 8;
    localparam int FULL_W  = HI_W + LO_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_MAIN_IDX = 4'd0,
        REG_MAIN_HI  = 4'd1,
        REG_MAIN_LO  = 4'd2,
        REG_AUX_IDX  = 4'd3,
        REG_AUX_DIV  = 4'd4
    } reg_sel_e;

    typedef struct packed {
        logic main_idx;
        logic main_hi;
        logic main_lo;
        logic aux_idx;
        logic aux_div;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en, input logic [ADDR_W-1:0] addr);
        wr_strobe_t s;
        s.main_idx = en && (addr == REG_MAIN_IDX);
        s.main_hi  = en && (addr == REG_MAIN_HI);
        s.main_lo  = en && (addr == REG_MAIN_LO);
        s.aux_idx  = en && (addr == REG_AUX_IDX);
        s.aux_div  = en && (addr == REG_AUX_DIV);
        return s;
    endfunction
endpackage

// File: rtl/frac_stage_dec.sv
module frac_stage_dec
    import frac_stage_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_strobe_t        strobe
);
    always_comb strobe = decode_write(wr_en, wr_addr);
endmodule

// File: rtl/frac_stage_chan.sv
module frac_stage_chan
    import frac_stage_pkg::*;
#(
    parameter bit SPLIT = 1'b1,
    localparam int OUT_W = SPLIT ? FULL_W : HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_we,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              int_mode,
    input  logic              narrow,
    output logic [IDX_W-1:0]  act_idx,
    output logic [OUT_W-1:0]  act_div,
    output logic              upd
);
    logic [IDX_W-1:0] sh_idx;
    logic [OUT_W-1:0] commit_div;
    logic [DATA_W-HI_W-1:0] unused_hi_bits;

    assign unused_hi_bits = wr_data[DATA_W-1:HI_W];

    generate
        if (SPLIT) begin : g_split
            logic [LO_W-1:0] sh_lo;
            always_ff @(posedge clk) begin
                if (rst)        sh_lo <= '0;
                else if (lo_we) sh_lo <= wr_data[LO_W-1:0];
            end
            always_comb begin
                if (narrow) commit_div = {{(OUT_W-HI_W){wr_data[HI_W-1]}}, wr_data[HI_W-1:0]};
                else        commit_div = {wr_data[HI_W-1:0], sh_lo};
            end

            AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
                hi_we && narrow |=> $signed(act_div) == $signed($past(wr_data[HI_W-1:0]))); // R5
        end else begin : g_plain
            logic unused_plain;
            assign unused_plain = lo_we ^ narrow;
            always_comb commit_div = wr_data[HI_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_idx  <= '0;
            act_idx <= '0;
            act_div <= '0;
            upd     <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (idx_we) begin
                sh_idx <= wr_data[IDX_W-1:0];
                if (int_mode) begin
                    act_idx <= wr_data[IDX_W-1:0];
                    upd     <= 1'b1;
                end
            end
            if (hi_we) begin
                act_idx <= sh_idx;
                act_div <= commit_div;
                upd     <= 1'b1;
            end
        end
    end

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        hi_we |=> upd); // R8

    AST_HOLD_WITHOUT_UPD: assert property (@(posedge clk) disable iff (rst)
        !upd && !$past(rst) |-> $stable(act_idx) && $stable(act_div)); // R3

    AST_INT_IDX_NOW: assert property (@(posedge clk) disable iff (rst)
        idx_we && int_mode && !hi_we |=> act_idx == $past(wr_data[IDX_W-1:0]) && $stable(act_div)); // R7

    AST_FRAC_IDX_WAITS: assert property (@(posedge clk) disable iff (rst)
        idx_we && !int_mode && !hi_we |=> $stable(act_idx)); // R3
endmodule

// File: rtl/frac_ratio_stage.sv
module frac_ratio_stage
    import frac_stage_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              main_int_mode,
    input  logic              main_res10,
    input  logic              aux_int_mode,
    output logic [IDX_W-1:0]  main_idx_o,
    output logic [FULL_W-1:0] main_div_o,
    output logic              main_upd_o,
    output logic [IDX_W-1:0]  aux_idx_o,
    output logic [HI_W-1:0]   aux_div_o,
    output logic              aux_upd_o
);
    wr_strobe_t strobe;

    frac_stage_dec u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .strobe  (strobe)
    );

    frac_stage_chan #(.SPLIT(1'b1)) u_main (
        .clk      (clk),
        .rst      (rst),
        .idx_we   (strobe.main_idx),
        .hi_we    (strobe.main_hi),
        .lo_we    (strobe.main_lo),
        .wr_data  (wr_data),
        .int_mode (main_int_mode),
        .narrow   (main_res10),
        .act_idx  (main_idx_o),
        .act_div  (main_div_o),
        .upd      (main_upd_o)
    );

    frac_stage_chan #(.SPLIT(1'b0)) u_aux (
        .clk      (clk),
        .rst      (rst),
        .idx_we   (strobe.aux_idx),
        .hi_we    (strobe.aux_div),
        .lo_we    (1'b0),
        .wr_data  (wr_data),
        .int_mode (aux_int_mode),
        .narrow   (1'b0),
        .act_idx  (aux_idx_o),
        .act_div  (aux_div_o),
        .upd      (aux_upd_o)
    );

    AST_SINGLE_CHANNEL_UPD: assert property (@(posedge clk) disable iff (rst)
        !(main_upd_o && aux_upd_o)); // R8

    AST_NO_WRITE_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !main_upd_o && !aux_upd_o); // R2
endmodule

// File: tb/frac_ratio_stage_bench.sv
`timescale 1ns/1ps
module frac_ratio_stage_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        main_int_mode = 1'b0;
    logic        main_res10 = 1'b0;
    logic        aux_int_mode = 1'b0;
    logic [8:0]  main_idx_o;
    logic [17:0] main_div_o;
    logic        main_upd_o;
    logic [8:0]  aux_idx_o;
    logic [9:0]  aux_div_o;
    logic        aux_upd_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    frac_ratio_stage u_frac_ratio_stage (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_int_mode(main_int_mode), .main_res10(main_res10), .aux_int_mode(aux_int_mode),
        .main_idx_o(main_idx_o), .main_div_o(main_div_o), .main_upd_o(main_upd_o),
        .aux_idx_o(aux_idx_o), .aux_div_o(aux_div_o), .aux_upd_o(aux_upd_o)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [11:0] d;
        logic        im;
        logic        r10;
        logic        ia;
        logic [8:0]  emi;
        logic [17:0] emd;
        logic        emu;
        logic [8:0]  eai;
        logic [9:0]  ead;
        logic        eau;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{4'd0, 12'd13,  1'b0, 1'b0, 1'b0, 9'd0,   18'h00000, 1'b0, 9'd0,   10'h000, 1'b0, 4'd3}, // R3 index to shadow
        '{4'd2, 12'h098, 1'b0, 1'b0, 1'b0, 9'd0,   18'h00000, 1'b0, 9'd0,   10'h000, 1'b0, 4'd3}, // R3 lower byte to shadow
        '{4'd1, 12'h07D, 1'b0, 1'b0, 1'b0, 9'd13,  18'h07D98, 1'b1, 9'd0,   10'h000, 1'b0, 4'd4}, // R4 wide commit
        '{4'd0, 12'd16,  1'b0, 1'b0, 1'b0, 9'd13,  18'h07D98, 1'b0, 9'd0,   10'h000, 1'b0, 4'd3}, // R3
        '{4'd1, 12'hF35, 1'b0, 1'b1, 1'b0, 9'd16,  18'h3FF35, 1'b1, 9'd0,   10'h000, 1'b0, 4'd5}, // R5 negative sext
        '{4'd2, 12'h0FF, 1'b0, 1'b1, 1'b0, 9'd16,  18'h3FF35, 1'b0, 9'd0,   10'h000, 1'b0, 4'd5}, // R5
        '{4'd1, 12'h004, 1'b0, 1'b1, 1'b0, 9'd16,  18'h00004, 1'b1, 9'd0,   10'h000, 1'b0, 4'd5}, // R5 lower byte ignored
        '{4'd3, 12'd18,  1'b0, 1'b1, 1'b0, 9'd16,  18'h00004, 1'b0, 9'd0,   10'h000, 1'b0, 4'd6}, // R6 aux shadow
        '{4'd4, 12'h200, 1'b0, 1'b1, 1'b0, 9'd16,  18'h00004, 1'b0, 9'd18,  10'h200, 1'b1, 4'd6}, // R6 aux commit
        '{4'd3, 12'h1FF, 1'b0, 1'b1, 1'b1, 9'd16,  18'h00004, 1'b0, 9'h1FF, 10'h200, 1'b1, 4'd7}, // R7 aux integer
        '{4'd0, 12'h100, 1'b1, 1'b1, 1'b1, 9'h100, 18'h00004, 1'b1, 9'h1FF, 10'h200, 1'b0, 4'd7}, // R7 main integer
        '{4'd5, 12'hFFF, 1'b1, 1'b1, 1'b1, 9'h100, 18'h00004, 1'b0, 9'h1FF, 10'h200, 1'b0, 4'd2}, // R2
        '{4'd15,12'hFFF, 1'b1, 1'b1, 1'b1, 9'h100, 18'h00004, 1'b0, 9'h1FF, 10'h200, 1'b0, 4'd2}, // R2
        '{4'd2, 12'h055, 1'b0, 1'b1, 1'b1, 9'h100, 18'h00004, 1'b0, 9'h1FF, 10'h200, 1'b0, 4'd9}, // R9 setup
        '{4'd1, 12'h3FF, 1'b0, 1'b0, 1'b1, 9'h100, 18'h3FF55, 1'b1, 9'h1FF, 10'h200, 1'b0, 4'd9}  // R9 flip on commit edge
    };

    task automatic check(input string tag, input logic [48:0] act, input logic [48:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [48:0] outs();
        return {main_idx_o, main_div_o, main_upd_o, aux_idx_o, aux_div_o, aux_upd_o};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), 49'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", outs(), 49'd0);

        for (int i = 0; i < NVEC; i++) begin
            wr_en = 1'b1;
            wr_addr = VEC[i].a;
            wr_data = VEC[i].d;
            main_int_mode = VEC[i].im;
            main_res10 = VEC[i].r10;
            aux_int_mode = VEC[i].ia;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), outs(),
                  {VEC[i].emi, VEC[i].emd, VEC[i].emu, VEC[i].eai, VEC[i].ead, VEC[i].eau});
        end

        // R8: pulse drops after one cycle when idle
        wr_en = 1'b0;
        @(negedge clk);
        check("R8 pulse ends", outs(), {9'h100, 18'h3FF55, 1'b0, 9'h1FF, 10'h200, 1'b0});

        // R2: address 1 with strobe low must not commit
        wr_addr = 4'd1;
        wr_data = 12'h001;
        @(negedge clk);
        check("R2 strobe low", outs(), {9'h100, 18'h3FF55, 1'b0, 9'h1FF, 10'h200, 1'b0});

        // R7: integer-mode index write keeps dividend, one pulse only (R8)
        wr_en = 1'b1;
        wr_addr = 4'd0;
        wr_data = 12'h0AA;
        main_int_mode = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 int index", outs(), {9'h0AA, 18'h3FF55, 1'b1, 9'h1FF, 10'h200, 1'b0});
        @(negedge clk);
        check("R8 int pulse ends", outs(), {9'h0AA, 18'h3FF55, 1'b0, 9'h1FF, 10'h200, 1'b0});

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", outs(), 49'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after mid-run reset", outs(), 49'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule